// File: doc/BRIEF.md
# Tuner Control Register Bank

This block is the register file that sits behind a 2-wire serial slave in an RF tuner controller. A simple address/data/strobe port stands in for the serial protocol engine: an 8-bit address selects one byte, a write strobe stores a byte and the read data bus returns the byte at the current address combinationally. Fifteen writable configuration bytes live at addresses 0x00 to 0x0E. Three read-only status bytes at 0x10, 0x11 and 0x12 reflect input buses that the analog side and the synthesizer drive.

The bank also turns a few configuration fields into control outputs. These are the per-block enables, a crystal-oscillator enable, a lock-detect multiplexer output and the charge-pump test-mode strobes. Two of these rules are specific to this tuner. The oscillator stays on unless two separate shutdown bits are both set. Main bias may shut down only once every other block, the VCO selector and the DC-offset loop are all off.

After reset, writes are locked out for a holdoff window that models the power-up settling time. The window is counted in system clocks, and its length is a parameter.

Top module: `tuner_ctrl_regs`

## Requirements
- R1: After reset, reads return the defaults 0x17 at 0x00, 0x00 at 0x01-0x03, 0x72 at 0x04, 0x01 at 0x05, 0x0A at 0x06, 0x08 at 0x07, 0x00 at 0x08, 0x50 at 0x09, 0xF3 at 0x0A, 0x71 at 0x0B and 0x00 at 0x0C-0x0E.
- R2: Writes that arrive within HOLDOFF_CYCLES clocks after reset is released leave every register unchanged.
- R3: After the holdoff, a write to an address from 0x00 to 0x0E is visible on rd_data in the cycle after the write strobe.
- R4: Writes to 0x0F, to 0x10-0x12 and to any address from 0x13 upward change no register, and reads of 0x0F or of 0x13 upward return 0x00.
- R5: Reads of 0x10, 0x11 and 0x12 return status_rom, status_chip and status_tune respectively.
- R6: The shutdown register at 0x08 holds the shutdown bits: reference buffer at bit 6, PLL at bit 4, RF at bit 3, baseband at bit 2, power detector at bit 1 and main bias at bit 0. Each block enable output is the inverse of its bit, except main bias, which follows R8.
- R7: xo_en is 0 only when both bit 6 and bit 4 of 0x08 are 1.
- R8: en_bias is 0 only when bits 6, 4, 3, 2, 1 and 0 of 0x08 are all 1, bits 7:6 of 0x09 (VCO select) are 00 and bits 5:4 of 0x0B (DC-offset mode) are 00.
- R9: mux_out follows bits 2:0 of 0x07. Code 000 gives the inverse of pll_locked (high means unlocked), 001 gives ndiv_half, 010 gives rdiv_half, and every other code gives 0.
- R10: Bits 7:5 of 0x07 drive the charge-pump strobes. Code 100 sets cp_lowz, 101 sets cp_src, 110 sets cp_sink and 111 sets cp_hiz. Every other code sets none of them, and at most one strobe is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for bus_addr |
| status_rom | input | 8 | Value returned at 0x10 |
| status_chip | input | 8 | Value returned at 0x11 |
| status_tune | input | 8 | Value returned at 0x12 |
| pll_locked | input | 1 | Synthesizer lock flag |
| ndiv_half | input | 1 | Feedback divider output halved |
| rdiv_half | input | 1 | Reference divider output halved |
| en_refbuf | output | 1 | Reference buffer enable |
| en_pll | output | 1 | PLL enable |
| en_rf | output | 1 | RF front end enable |
| en_bb | output | 1 | Baseband chain enable |
| en_pd | output | 1 | Power detector enable |
| en_bias | output | 1 | Main bias enable |
| xo_en | output | 1 | Crystal oscillator enable |
| mux_out | output | 1 | Lock-detect / test multiplexer output |
| cp_lowz | output | 1 | Charge pump forced low impedance |
| cp_src | output | 1 | Charge pump forced source |
| cp_sink | output | 1 | Charge pump forced sink |
| cp_hiz | output | 1 | Charge pump forced high impedance |

## Verification
The state that is hardest to reach from the ports is main bias turning off. It needs three registers at once to hold particular values: every other shutdown bit set, VCO select cleared and the DC-offset mode cleared, and both defaults keep the last two non-zero. The stimulus builds that state with a directed write sequence and then removes one condition at a time to show that bias comes back. Random writes, weighted towards the four decoded registers, cover the multiplexer codes and the charge-pump codes. The holdoff is checked by writing before it expires and reading the defaults back afterwards.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    parameter int DATA_W  = 8;
    parameter int ADDR_W  = 8;
    parameter int NUM_WR  = 15;
    parameter int NUM_RO  = 3;
    parameter int RO_BASE = 16;

    localparam int A_TEST = 7;
    localparam int A_SHDN = 8;
    localparam int A_VCO  = 9;
    localparam int A_DCOF = 11;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic refbuf;
        logic pll;
        logic rf;
        logic bb;
        logic pd;
        logic bias;
    } blk_en_t;

    typedef enum logic [2:0] {
        CP_NORMAL = 3'b000,
        CP_LOWZ   = 3'b100,
        CP_SRC    = 3'b101,
        CP_SINK   = 3'b110,
        CP_HIZ    = 3'b111
    } cp_mode_e;

    typedef enum logic [2:0] {
        MX_LOCK = 3'b000,
        MX_NDIV = 3'b001,
        MX_RDIV = 3'b010
    } mux_sel_e;

    function automatic byte_t reg_default(input int idx);
        case (idx)
            0:       return byte_t'(8'h17);
            4:       return byte_t'(8'h72);
            5:       return byte_t'(8'h01);
            6:       return byte_t'(8'h0A);
            7:       return byte_t'(8'h08);
            9:       return byte_t'(8'h50);
            10:      return byte_t'(8'hF3);
            11:      return byte_t'(8'h71);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/tcr_holdoff.sv
module tcr_holdoff #(
    parameter int HOLDOFF_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(HOLDOFF_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != TERM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == TERM);

    // once open, the write window stays open until reset
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
endmodule

// File: rtl/tcr_regfile.sv
module tcr_regfile
    import tcr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_ok,
    input  logic                     wr_en,
    input  addr_t                    addr,
    input  byte_t                    wr_data,
    input  logic [NUM_RO-1:0][DATA_W-1:0] status_in,
    output byte_t                    rd_data,
    output logic [NUM_WR-1:0][DATA_W-1:0] regs_q
);
    for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && wr_ok && (addr == addr_t'(g));
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reg_default(g);
            else if (hit)
                regs_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WR; i++)
            if (addr == addr_t'(i)) rd_data = regs_q[i];
        for (int j = 0; j < NUM_RO; j++)
            if (addr == addr_t'(RO_BASE + j)) rd_data = status_in[j];
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> $stable(regs_q));

    p_unmapped_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= addr_t'(NUM_WR)) |=> $stable(regs_q));

    p_wr_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ok && addr < addr_t'(NUM_WR))
        |=> regs_q[$past(addr[3:0])] == $past(wr_data));
endmodule

// File: rtl/tcr_decode.sv
module tcr_decode
    import tcr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  byte_t   test_reg,
    input  byte_t   shdn_reg,
    input  byte_t   vco_reg,
    input  byte_t   dcof_reg,
    input  logic    pll_locked,
    input  logic    ndiv_half,
    input  logic    rdiv_half,
    output blk_en_t en,
    output logic    xo_en,
    output logic    mux_out,
    output logic    cp_lowz,
    output logic    cp_src,
    output logic    cp_sink,
    output logic    cp_hiz
);
    logic sd_ref, sd_syn, sd_rf, sd_bb, sd_pd, sd_bg;
    logic others_off;
    cp_mode_e cp_mode;

    assign sd_ref = shdn_reg[6];
    assign sd_syn = shdn_reg[4];
    assign sd_rf  = shdn_reg[3];
    assign sd_bb  = shdn_reg[2];
    assign sd_pd  = shdn_reg[1];
    assign sd_bg  = shdn_reg[0];

    assign others_off = sd_ref && sd_syn && sd_rf && sd_bb && sd_pd
                        && (vco_reg[7:6] == 2'b00) && (dcof_reg[5:4] == 2'b00);

    always_comb begin
        en.refbuf = !sd_ref;
        en.pll    = !sd_syn;
        en.rf     = !sd_rf;
        en.bb     = !sd_bb;
        en.pd     = !sd_pd;
        en.bias   = !(sd_bg && others_off);
    end

    assign xo_en = !(sd_ref && sd_syn);

    always_comb begin
        case (mux_sel_e'(test_reg[2:0]))
            MX_LOCK: mux_out = !pll_locked;
            MX_NDIV: mux_out = ndiv_half;
            MX_RDIV: mux_out = rdiv_half;
            default: mux_out = 1'b0;
        endcase
    end

    assign cp_mode = cp_mode_e'(test_reg[7:5]);

    always_comb begin
        cp_lowz = 1'b0;
        cp_src  = 1'b0;
        cp_sink = 1'b0;
        cp_hiz  = 1'b0;
        case (cp_mode)
            CP_LOWZ: cp_lowz = 1'b1;
            CP_SRC:  cp_src  = 1'b1;
            CP_SINK: cp_sink = 1'b1;
            CP_HIZ:  cp_hiz  = 1'b1;
            default: ;
        endcase
    end

    p_xo_pll_r7: assert property (@(posedge clk) disable iff (rst)
        (en.pll || en.refbuf) |-> xo_en);

    p_bias_last_r8: assert property (@(posedge clk) disable iff (rst)
        !en.bias |-> (!en.refbuf && !en.pll && !en.rf && !en.bb && !en.pd && !xo_en));

    p_cp_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cp_lowz, cp_src, cp_sink, cp_hiz}));
endmodule

// File: rtl/tuner_ctrl_regs.sv
module tuner_ctrl_regs
    import tcr_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] status_rom,
    input  logic [DATA_W-1:0] status_chip,
    input  logic [DATA_W-1:0] status_tune,
    input  logic              pll_locked,
    input  logic              ndiv_half,
    input  logic              rdiv_half,
    output logic              en_refbuf,
    output logic              en_pll,
    output logic              en_rf,
    output logic              en_bb,
    output logic              en_pd,
    output logic              en_bias,
    output logic              xo_en,
    output logic              mux_out,
    output logic              cp_lowz,
    output logic              cp_src,
    output logic              cp_sink,
    output logic              cp_hiz
);
    logic                           wr_ok;
    logic [NUM_RO-1:0][DATA_W-1:0]  status_bus;
    logic [NUM_WR-1:0][DATA_W-1:0]  regs;
    blk_en_t                        en;

    assign status_bus = {status_tune, status_chip, status_rom};

    tcr_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
        .clk   (clk),
        .rst   (rst),
        .ready (wr_ok)
    );

    tcr_regfile u_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (wr_ok),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wr_data   (bus_wdata),
        .status_in (status_bus),
        .rd_data   (bus_rdata),
        .regs_q    (regs)
    );

    tcr_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .test_reg   (regs[A_TEST]),
        .shdn_reg   (regs[A_SHDN]),
        .vco_reg    (regs[A_VCO]),
        .dcof_reg   (regs[A_DCOF]),
        .pll_locked (pll_locked),
        .ndiv_half  (ndiv_half),
        .rdiv_half  (rdiv_half),
        .en         (en),
        .xo_en      (xo_en),
        .mux_out    (mux_out),
        .cp_lowz    (cp_lowz),
        .cp_src     (cp_src),
        .cp_sink    (cp_sink),
        .cp_hiz     (cp_hiz)
    );

    assign en_refbuf = en.refbuf;
    assign en_pll    = en.pll;
    assign en_rf     = en.rf;
    assign en_bb     = en.bb;
    assign en_pd     = en.pd;
    assign en_bias   = en.bias;
endmodule

// File: tb/tuner_ctrl_regs_tb.sv
module tuner_ctrl_regs_tb;
    localparam int HOLD = 12500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic we = 1'b0;
    logic [7:0] rdata;
    logic [7:0] st_rom = '0, st_chip = '0, st_tune = '0;
    logic locked = 1'b0, ndh = 1'b0, rdh = 1'b0;
    logic e_ref, e_pll, e_rf, e_bb, e_pd, e_bias, xo, mx, c_lz, c_src, c_snk, c_hz;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [0:14];

    always #4 clk = ~clk;

    tuner_ctrl_regs #(.HOLDOFF_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .bus_rdata(rdata), .status_rom(st_rom), .status_chip(st_chip),
        .status_tune(st_tune), .pll_locked(locked), .ndiv_half(ndh),
        .rdiv_half(rdh), .en_refbuf(e_ref), .en_pll(e_pll), .en_rf(e_rf),
        .en_bb(e_bb), .en_pd(e_pd), .en_bias(e_bias), .xo_en(xo),
        .mux_out(mx), .cp_lowz(c_lz), .cp_src(c_src), .cp_sink(c_snk),
        .cp_hiz(c_hz)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int a);
        logic [7:0] t [0:14];
        t = '{8'h17, 8'h00, 8'h00, 8'h00, 8'h72, 8'h01, 8'h0A, 8'h08,
              8'h00, 8'h50, 8'hF3, 8'h71, 8'h00, 8'h00, 8'h00};
        return t[a];
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a < 8'd15) return model[a];
        if (a == 8'h10) return st_rom;
        if (a == 8'h11) return st_chip;
        if (a == 8'h12) return st_tune;
        return 8'h00;
    endfunction

    // enables packed as {ref,pll,rf,bb,pd,bias,xo} into bits 6..0
    function automatic logic [7:0] exp_en();
        logic [7:0] s;
        logic all_off;
        s = model[8];
        all_off = s[6] & s[4] & s[3] & s[2] & s[1] & s[0]
                  & (model[9][7:6] == 2'b00) & (model[11][5:4] == 2'b00);
        return {1'b0, ~s[6], ~s[4], ~s[3], ~s[2], ~s[1], ~all_off, ~(s[6] & s[4])};
    endfunction

    function automatic logic exp_mux();
        case (model[7][2:0])
            3'b000:  return ~locked;
            3'b001:  return ndh;
            3'b010:  return rdh;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_cp();
        case (model[7][7:5])
            3'b100:  return 8'b0001;
            3'b101:  return 8'b0010;
            3'b110:  return 8'b0100;
            3'b111:  return 8'b1000;
            default: return 8'b0000;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit live);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (live && a < 8'd15) model[a] = d;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        addr = a;
        #1;
        check(req, rdata, exp_read(a));
    endtask

    task automatic check_decode();
        #1;
        check("R6/R7/R8 enables", {1'b0, e_ref, e_pll, e_rf, e_bb, e_pd, e_bias, xo}, exp_en());
        check("R9 mux_out", {7'd0, mx}, {7'd0, exp_mux()});
        check("R10 cp strobes", {4'd0, c_hz, c_snk, c_src, c_lz}, exp_cp());
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 15; i++) model[i] = dflt(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: defaults and decode at reset
        for (int a = 0; a < 15; a++) rd_check("R1 default", 8'(a));
        check_decode();

        // R2: writes during holdoff are dropped
        wr(8'h00, 8'hAA, 1'b0);
        wr(8'h08, 8'h5F, 1'b0);
        wr(8'h07, 8'hE1, 1'b0);
        rd_check("R2 early write 0x00", 8'h00);
        rd_check("R2 early write 0x08", 8'h08);
        check_decode();

        repeat (HOLD + 10) @(negedge clk);

        // R3: basic write after holdoff
        wr(8'h00, 8'h5A, 1'b1);
        rd_check("R3 write 0x00", 8'h00);
        wr(8'h0E, 8'hC3, 1'b1);
        rd_check("R3 write 0x0E", 8'h0E);

        // R4: unused and read-only addresses
        wr(8'h0F, 8'hFF, 1'b1);
        wr(8'h10, 8'hFF, 1'b1);
        wr(8'h12, 8'hFF, 1'b1);
        wr(8'hFF, 8'hFF, 1'b1);
        rd_check("R4 read 0x0F", 8'h0F);
        rd_check("R4 read 0x13", 8'h13);
        rd_check("R4 read 0xFF", 8'hFF);
        for (int a = 0; a < 15; a++) rd_check("R4 no side effect", 8'(a));

        // R5: status readback
        st_rom = 8'h3C; st_chip = 8'hA5; st_tune = 8'h81;
        rd_check("R5 status 0x10", 8'h10);
        rd_check("R5 status 0x11", 8'h11);
        rd_check("R5 status 0x12", 8'h12);

        // R7: oscillator corner
        wr(8'h08, 8'h50, 1'b1); check_decode();
        wr(8'h08, 8'h40, 1'b1); check_decode();
        wr(8'h08, 8'h10, 1'b1); check_decode();

        // R8: bias can turn off only with everything else off
        wr(8'h08, 8'h5F, 1'b1); check_decode();
        wr(8'h09, 8'h10, 1'b1); check_decode();
        wr(8'h0B, 8'h41, 1'b1); check_decode();
        check("R8 bias off", {7'd0, e_bias}, 8'h00);
        wr(8'h08, 8'h5D, 1'b1); check_decode();
        wr(8'h08, 8'h5F, 1'b1); check_decode();
        wr(8'h09, 8'h40, 1'b1); check_decode();
        wr(8'h09, 8'h00, 1'b1);
        wr(8'h0B, 8'h51, 1'b1); check_decode();

        // R9/R10: every code of the test register
        for (int c = 0; c < 8; c++) begin
            wr(8'h07, 8'((c << 5) | c), 1'b1);
            for (int k = 0; k < 4; k++) begin
                locked = k[0]; ndh = k[1]; rdh = ~k[0];
                check_decode();
            end
        end

        // random mix weighted towards decoded registers
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a, d;
            case ($urandom_range(0, 5))
                0: a = 8'h07;
                1: a = 8'h08;
                2: a = 8'h09;
                3: a = 8'h0B;
                4: a = 8'($urandom_range(0, 31));
                default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            if ($urandom_range(0, 3) == 0) d = d | 8'h5F;
            wr(a, d, 1'b1);
            locked = 1'($urandom); ndh = 1'($urandom); rdh = 1'($urandom);
            st_rom = 8'($urandom); st_chip = 8'($urandom); st_tune = 8'($urandom);
            rd_check("R3/R4/R5 random read", a);
            check_decode();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule